// File: doc/BRIEF.md
# Preamble-Aligned Raw Bit Deserializer and Serializer

This block sits on the receive side of a radio data path, between the demodulator's bit stream and a byte consumer. In free-running mode it groups incoming bits into bytes with no delimiting and no byte synchronization. In preamble-matched mode it throws every bit away until a programmable pattern of 4 to 32 bits shows up in the stream. It then locks its byte boundary to the end of that pattern and delivers bytes from the next bit onward.

A small transmit serializer sits beside it. It takes one byte at a time and shifts it out one bit per step strobe. No framing is added.

The block stays locked after a match. A resynchronize pulse or a change of mode returns it to searching. In free-running mode the same events throw away a partly assembled byte.

Top module: `raw_frame_aligner`

## Requirements
- R1: In free-running mode (`match_mode_i`=0) each accepted bit is shifted into the byte with the first received bit at bit 0. On the clock edge that samples the eighth bit, `rx_byte_o` takes the byte and `rx_byte_valid_o` goes high for exactly one cycle.
- R2: In matched mode (`match_mode_i`=1) no byte is delivered while the block is searching for the pattern.
- R3: With effective length N, a match occurs when the last N accepted bits equal `pat_i[N-1:0]`. The oldest of those bits is compared with bit N-1 and the newest with bit 0. `match_o` is high for the one cycle after the edge that samples the completing bit.
- R4: The bit that follows a match is bit 0 of a new byte.
- R5: A `pat_len_i` value below 4 acts as 4, and a value above 32 acts as 32.
- R6: Only bits accepted since the search began count toward a match. Fewer than N such bits never produce a match, even when the pattern is all zeros.
- R7: Once locked, the block produces no further `match_o` pulses, even if the pattern appears again. Bytes keep flowing until a resync or a mode change.
- R8: A `resync_i` pulse, or a change of `match_mode_i`, returns the block to searching and discards any partial byte. A bit that arrives in that same cycle is dropped.
- R9: The serializer accepts `tx_data_i` when `tx_load_i` is high and `tx_ready_o` is high. After k step strobes, `tx_bit_o` shows data bit k. `tx_bit_valid_o` stays high for all 8 bits. `tx_ready_o` returns after the eighth step. A load while busy is ignored.
- R10: A cycle in which `rx_valid_i` is low has no effect on pattern search or byte assembly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| match_mode_i | input | 1 | 0 = free-running, 1 = preamble-matched |
| resync_i | input | 1 | Return to search / drop partial byte |
| pat_i | input | 32 | Preamble pattern, low N bits used |
| pat_len_i | input | 6 | Preamble length N (clamped to 4..32) |
| rx_bit_i | input | 1 | Received bit |
| rx_valid_i | input | 1 | Received bit is valid this cycle |
| rx_byte_o | output | 8 | Assembled byte |
| rx_byte_valid_o | output | 1 | One-cycle pulse, new byte |
| match_o | output | 1 | One-cycle pulse, preamble found |
| tx_data_i | input | 8 | Byte to serialize |
| tx_load_i | input | 1 | Load request for tx_data_i |
| tx_ready_o | output | 1 | Serializer idle, can take a byte |
| tx_step_i | input | 1 | Advance to the next transmit bit |
| tx_bit_o | output | 1 | Current transmit bit |
| tx_bit_valid_o | output | 1 | Transmit bit is meaningful |

## Verification
Every receive result has one register between input and output. `match_o` and `rx_byte_valid_o` follow one edge after the bit that completes the pattern or the byte, and the serializer's bit changes one edge after a step strobe. The bench drives inputs on falling edges and logs outputs on falling edges, so each result is read half a period after the edge that produced it. A monitor records each match against a count of accepted bits taken at rising edges. The bench can therefore check the exact bit index at which the match fired, not just that a match happened. The byte-timing check reads `rx_byte_valid_o` at the very falling edge after the eighth bit, and again one cycle later to confirm the pulse is one cycle wide.

// File: rtl/raw_pkg.sv
package raw_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } lock_st_e;
endpackage

// File: rtl/preamble_detect.sv
module preamble_detect #(
  parameter int HIST_W  = 32,
  parameter int MIN_LEN = 4,
  parameter int LEN_W   = $clog2(HIST_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic [HIST_W-1:0] pat_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              hit_o
);
  logic [HIST_W-1:0] hist_q, hist_nx, mask;
  logic [LEN_W-1:0]  fill_q, len_eff;

  always_comb begin
    if (len_i < LEN_W'(MIN_LEN))     len_eff = LEN_W'(MIN_LEN);
    else if (len_i > LEN_W'(HIST_W)) len_eff = LEN_W'(HIST_W);
    else                             len_eff = len_i;
  end

  // shift by HIST_W yields zero, so mask becomes all ones
  assign mask    = ~({HIST_W{1'b1}} << len_eff);
  assign hist_nx = {hist_q[HIST_W-2:0], bit_i};
  assign hit_o   = shift_i && (fill_q >= len_eff - LEN_W'(1)) &&
                   (((hist_nx ^ pat_i) & mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift_i) begin
      hist_q <= hist_nx;
      if (fill_q != LEN_W'(HIST_W)) fill_q <= fill_q + LEN_W'(1);
    end
  end

  p_clr_no_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !hit_o);

endmodule

// File: rtl/byte_assembler.sv
module byte_assembler #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] sh_q, sh_nx;
  logic [CNT_W-1:0]  cnt_q;

  assign sh_nx = {bit_i, sh_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (en_i) begin
        sh_q <= sh_nx;
        if (cnt_q == CNT_W'(DATA_W - 1)) begin
          cnt_q   <= '0;
          byte_o  <= sh_nx;
          valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  p_valid_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_valid_from_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(en_i && !clr_i));

endmodule

// File: rtl/byte_serializer.sv
module byte_serializer #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              step_i,
  output logic              ready_o,
  output logic              bit_o,
  output logic              bit_valid_o
);
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;

  assign ready_o     = !busy_q;
  assign bit_o       = sh_q[0];
  assign bit_valid_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        sh_q   <= data_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end
    end else if (step_i) begin
      sh_q <= sh_q >> 1;
      if (cnt_q == CNT_W'(DATA_W - 1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  p_tx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !step_i) |=> ($stable(sh_q) && busy_q));
  p_tx_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && load_i) |=> (busy_q && bit_o == $past(data_i[0])));

endmodule

// File: rtl/raw_frame_aligner.sv
module raw_frame_aligner #(
  parameter int DATA_W  = 8,
  parameter int HIST_W  = 32,
  parameter int MIN_LEN = 4,
  parameter int LEN_W   = $clog2(HIST_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              match_mode_i,
  input  logic              resync_i,
  input  logic [HIST_W-1:0] pat_i,
  input  logic [LEN_W-1:0]  pat_len_i,
  input  logic              rx_bit_i,
  input  logic              rx_valid_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_byte_valid_o,
  output logic              match_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic              tx_ready_o,
  input  logic              tx_step_i,
  output logic              tx_bit_o,
  output logic              tx_bit_valid_o
);
  import raw_pkg::*;

  lock_st_e st_q;
  logic     mode_q, restart, bit_ok, searching, hit, hit_fire, pass;

  assign restart   = resync_i || (match_mode_i != mode_q);
  assign bit_ok    = rx_valid_i && !restart;
  assign searching = match_mode_i && (st_q == ST_SEARCH);
  assign hit_fire  = bit_ok && searching && hit;
  assign pass      = bit_ok && (!match_mode_i || st_q == ST_LOCKED);

  preamble_detect #(
    .HIST_W (HIST_W),
    .MIN_LEN(MIN_LEN),
    .LEN_W  (LEN_W)
  ) i_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .shift_i(bit_ok && searching),
    .bit_i  (rx_bit_i),
    .pat_i  (pat_i),
    .len_i  (pat_len_i),
    .hit_o  (hit)
  );

  byte_assembler #(.DATA_W(DATA_W)) i_assemble (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart || hit_fire),
    .en_i   (pass),
    .bit_i  (rx_bit_i),
    .byte_o (rx_byte_o),
    .valid_o(rx_byte_valid_o)
  );

  byte_serializer #(.DATA_W(DATA_W)) i_serialize (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tx_load_i),
    .data_i     (tx_data_i),
    .step_i     (tx_step_i),
    .ready_o    (tx_ready_o),
    .bit_o      (tx_bit_o),
    .bit_valid_o(tx_bit_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_SEARCH;
      mode_q  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      mode_q  <= match_mode_i;
      match_o <= hit_fire;
      if (restart)       st_q <= ST_SEARCH;
      else if (hit_fire) st_q <= ST_LOCKED;
    end
  end

  p_no_byte_search_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_byte_valid_o |-> $past(!match_mode_i || st_q == ST_LOCKED));
  p_match_locks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (st_q == ST_LOCKED));
  p_match_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);
  p_restart_search_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (st_q == ST_SEARCH && !match_o));

endmodule

// File: tb/test_raw_frame_aligner.sv
module test_raw_frame_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0, resync = 1'b0;
  logic [31:0] pat = '0;
  logic [5:0]  plen = 6'd8;
  logic        rx_bit = 1'b0, rx_valid = 1'b0;
  logic [7:0]  rx_byte;
  logic        rx_byte_valid, match;
  logic [7:0]  tx_data = '0;
  logic        tx_load = 1'b0, tx_step = 1'b0;
  logic        tx_ready, tx_bit, tx_bit_valid;

  int total = 0, bad = 0;
  int bits_seen = 0, n_got = 0, n_match = 0, match_at = 0;
  logic [7:0] got [0:63];

  always #2.5 clk = ~clk;

  raw_frame_aligner i_raw_frame_aligner (
    .clk_i(clk), .rst_ni(rst_n), .match_mode_i(mode), .resync_i(resync),
    .pat_i(pat), .pat_len_i(plen), .rx_bit_i(rx_bit), .rx_valid_i(rx_valid),
    .rx_byte_o(rx_byte), .rx_byte_valid_o(rx_byte_valid), .match_o(match),
    .tx_data_i(tx_data), .tx_load_i(tx_load), .tx_ready_o(tx_ready),
    .tx_step_i(tx_step), .tx_bit_o(tx_bit), .tx_bit_valid_o(tx_bit_valid)
  );

  always @(posedge clk) if (rst_n && rx_valid) bits_seen <= bits_seen + 1;

  always @(negedge clk) begin
    if (rst_n && rx_byte_valid) begin
      got[n_got[5:0]] = rx_byte;
      n_got = n_got + 1;
    end
    if (rst_n && match) begin
      n_match = n_match + 1;
      match_at = bits_seen;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rx_bit = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic send_pat(input logic [31:0] p, input int len);
    for (int i = len - 1; i >= 0; i--) send_bit(p[i]);
  endtask

  task automatic pulse_resync(input logic with_bit);
    resync = 1'b1; rx_valid = with_bit; rx_bit = 1'b1;
    @(negedge clk);
    resync = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    mode = m;
    idle(2);
  endtask

  task automatic t_reset;
    chk(rx_byte_valid == 1'b0, "R1 reset byte valid", rx_byte_valid, 0);
    chk(match == 1'b0, "R3 reset match", match, 0);
    chk(tx_ready == 1'b1, "R9 reset tx ready", tx_ready, 1);
    chk(tx_bit_valid == 1'b0, "R9 reset tx valid", tx_bit_valid, 0);
  endtask

  task automatic t_free;
    int g0;
    set_mode(1'b0);
    g0 = n_got;
    send_byte(8'hA5);
    chk(rx_byte_valid == 1'b1, "R1 valid after 8th bit", rx_byte_valid, 1);
    chk(rx_byte == 8'hA5, "R1 byte lsb first", rx_byte, 8'hA5);
    idle(1);
    chk(rx_byte_valid == 1'b0, "R1 valid one cycle", rx_byte_valid, 0);
    for (int i = 0; i < 8; i++) begin
      send_bit(8'h3C >> i);
      rx_bit = ~rx_bit;  // toggled bit with valid low must be ignored
      idle(2);
    end
    idle(1);
    chk(n_got == g0 + 2, "R10 byte count with gaps", n_got, g0 + 2);
    chk(got[(g0 + 1) % 64] == 8'h3C, "R10 gapped byte", got[(g0 + 1) % 64], 8'h3C);
  endtask

  task automatic t_match;
    int g0, m0, base;
    set_mode(1'b1);
    pulse_resync(1'b0);
    pat = 32'h0000_0B2D; plen = 6'd12;
    g0 = n_got; m0 = n_match; base = bits_seen;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_pat(pat, 12);
    idle(1);
    chk(n_match == m0 + 1, "R3 one match", n_match, m0 + 1);
    chk(match_at == base + 16, "R3 match bit index", match_at, base + 16);
    chk(n_got == g0, "R2 no bytes while searching", n_got, g0);
    send_byte(8'h96);
    idle(1);
    chk(n_got == g0 + 1, "R4 one byte after match", n_got, g0 + 1);
    chk(got[g0 % 64] == 8'h96, "R4 aligned byte", got[g0 % 64], 8'h96);
  endtask

  task automatic t_locked;
    int g0, m0;
    g0 = n_got; m0 = n_match;
    send_pat(32'h0000_0B2D, 12);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    idle(1);
    chk(n_match == m0, "R7 no match while locked", n_match, m0);
    chk(n_got == g0 + 2, "R7 bytes keep flowing", n_got, g0 + 2);
    chk(got[g0 % 64] == 8'h4D, "R7 first locked byte", got[g0 % 64], 8'h4D);
    chk(got[(g0 + 1) % 64] == 8'h0B, "R7 second locked byte", got[(g0 + 1) % 64], 8'h0B);
  endtask

  task automatic t_resync;
    int g0, m0, base;
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    pulse_resync(1'b0);
    m0 = n_match; g0 = n_got; base = bits_seen;
    send_pat(32'h0000_0B2D, 12);
    send_byte(8'h5A);
    idle(1);
    chk(n_match == m0 + 1, "R8 re-search matches", n_match, m0 + 1);
    chk(match_at == base + 12, "R8 match index after resync", match_at, base + 12);
    chk(got[g0 % 64] == 8'h5A && n_got == g0 + 1, "R8 byte after resync", got[g0 % 64], 8'h5A);
    // mode change while locked: partial byte dropped
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    set_mode(1'b0);
    g0 = n_got;
    send_byte(8'h77);
    idle(1);
    chk(n_got == g0 + 1 && got[g0 % 64] == 8'h77, "R8 mode change clears", got[g0 % 64], 8'h77);
    // free mode: resync with a bit in the same cycle
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    pulse_resync(1'b1);
    g0 = n_got;
    send_byte(8'hE1);
    idle(1);
    chk(n_got == g0 + 1 && got[g0 % 64] == 8'hE1, "R8 resync bit dropped", got[g0 % 64], 8'hE1);
  endtask

  task automatic t_fill;
    int m0, base;
    set_mode(1'b1);
    pat = 32'h0; plen = 6'd8;
    pulse_resync(1'b0);
    m0 = n_match; base = bits_seen;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    idle(1);
    chk(n_match == m0, "R6 no match on short history", n_match, m0);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    idle(1);
    chk(n_match == m0 + 1 && match_at == base + 8, "R6 match after N bits", match_at, base + 8);
  endtask

  task automatic t_clamp;
    int m0, base;
    pat = 32'hFFFF_FFF9; plen = 6'd2;
    pulse_resync(1'b0);
    m0 = n_match; base = bits_seen;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    idle(1);
    chk(n_match == m0 + 1 && match_at == base + 6, "R5 low length clamped to 4", match_at, base + 6);
    pat = 32'hA5A5_0F0F; plen = 6'd63;
    pulse_resync(1'b0);
    m0 = n_match; base = bits_seen;
    send_pat(pat, 32);
    idle(1);
    chk(n_match == m0 + 1 && match_at == base + 32, "R5 high length clamped to 32", match_at, base + 32);
  endtask

  task automatic t_tx;
    logic [7:0] d = 8'hC6;
    tx_data = d; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    chk(tx_bit_valid == 1'b1 && tx_ready == 1'b0, "R9 busy after load", tx_bit_valid, 1);
    for (int k = 0; k < 8; k++) begin
      chk(tx_bit == d[k], "R9 serial bit", tx_bit, d[k]);
      if (k == 3) begin
        tx_data = 8'hFF; tx_load = 1'b1;  // ignored while busy
        idle(2);
        tx_load = 1'b0;
        chk(tx_bit == d[k], "R9 hold without step", tx_bit, d[k]);
      end
      tx_step = 1'b1;
      @(negedge clk);
      tx_step = 1'b0;
    end
    chk(tx_ready == 1'b1 && tx_bit_valid == 1'b0, "R9 ready after 8 steps", tx_ready, 1);
    tx_data = 8'h3A; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    chk(tx_bit == 1'b0 && tx_bit_valid == 1'b1, "R9 second load", tx_bit, 0);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_free();
    t_match();
    t_locked();
    t_resync();
    t_fill();
    t_clamp();
    t_tx();
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule